// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block sits at the front of a floating-point datapath. It takes one raw 64-bit binary64 word per cycle and splits it into a class code, a sign, a signed exponent with the bias removed, and a widened mantissa. Later stages (add, multiply, round) can then work on a single uniform form. The mantissa carries the hidden one at its top bit and three spare low bits. A rounding stage downstream uses those three bits as guard, round and sticky positions. At this stage they are always zero.

Subnormal operands are renormalized here. A leading-zero counter finds the first set bit of the fraction. A barrel shifter moves that bit up to the hidden-one position, and the exponent is corrected by the same amount. As a result, every operand that leaves as class "normal" has its top mantissa bit set. The result is registered. `valid_out` marks the cycle after a sampled `valid_in`, and the result fields hold their last value between operands.

Top module: `fp_operand_unpack`

## Requirements
- R1: `sign_out` equals bit 63 of the accepted word, for every class.
- R2: An exponent field (bits 62:52) of all ones with a zero fraction (bits 51:0) gives class code 2'b11 (infinity), `exp_out` 0 and `mant_out` 0.
- R3: An all-ones exponent field with a nonzero fraction gives class code 2'b10 (NaN), `exp_out` 0, and `mant_out` equal to the fraction placed at bits 54:3, with bits 55 and 2:0 clear.
- R4: A zero exponent field with a zero fraction gives class code 2'b01 (zero), `exp_out` 0 and `mant_out` 0.
- R5: Any other nonzero exponent field E gives class code 2'b00 (normal), `exp_out` = E - 1023 as a 13-bit two's-complement value, and `mant_out` = {1, fraction, 3'b000}, so the hidden one sits at bit 55.
- R6: A zero exponent field with a nonzero fraction gives class code 2'b00. `mant_out` is the fraction shifted left until its highest set bit reaches bit 55, with zeros filled below. `exp_out` = -1023 - L, where L is the number of leading zeros of the 52-bit fraction. For example, a fraction of 1 gives -1074 and `mant_out` = 1<<55.
- R7: `valid_out` is high in exactly the cycle after each cycle in which `valid_in` was sampled high. Operands may arrive on back-to-back cycles.
- R8: When `valid_in` is sampled low, `class_out`, `sign_out`, `exp_out` and `mant_out` keep their previous values, whatever is on `word_in`.
- R9: A synchronous reset clears `valid_out` and sets every result output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Qualifies `word_in` in this cycle |
| word_in | input | 64 | Raw binary64 operand |
| valid_out | output | 1 | Result fields below are fresh this cycle |
| class_out | output | 2 | 00 normal, 01 zero, 10 NaN, 11 infinity |
| sign_out | output | 1 | Sign of the operand |
| exp_out | output | 13 | Unbiased exponent, two's complement |
| mant_out | output | 56 | Hidden one at bit 55, bits 2:0 spare for guard/round/sticky |

## Verification
Every result field and `valid_out` is due exactly one rising edge after the edge that samples the operand, and nothing is held back longer. The bench drives each operand on a falling edge and compares all outputs on the following falling edge against a behavioural model that advances one step per clock. An idle cycle is therefore checked as a hold of the previous values (R8), and a reset cycle is checked as all-zero outputs (R9). Directed words cover each class, both ends of the normal range and the subnormal extremes. A long pseudo-random stream, biased toward zero and all-ones exponents, follows with gaps and back-to-back operands mixed in.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

   // Operand class codes seen by downstream stages.
   typedef enum logic [1:0] {
      FCLS_NORM = 2'b00,
      FCLS_ZERO = 2'b01,
      FCLS_NAN  = 2'b10,
      FCLS_INF  = 2'b11
   } fcls_e;

   // Width of a padded power-of-two window around n bits.
   function automatic int pow2_ceil(input int n);
      int p;
      p = 1;
      while (p < n) p = p * 2;
      return p;
   endfunction

endpackage

// File: rtl/fpu_lzc.sv
// Leading-zero counter built as a chain of halving range tests:
// each stage asks whether the upper half of the remaining window is
// empty, records one count bit, and slides the window if so.
module fpu_lzc #(
   parameter int IN_W  = 52,
   parameter int PAD_W = fpu_unpack_pkg::pow2_ceil(IN_W),
   parameter int CNT_W = $clog2(PAD_W)
) (
   input  logic [IN_W-1:0]  vec_i,
   output logic [CNT_W-1:0] zeros_o
);

   localparam int STAGES = CNT_W;

   logic [PAD_W-1:0] win [0:STAGES-1];
   logic [CNT_W-1:0] cnt;

   // Pad on the low side so that leading zeros are unchanged.
   generate
      if (PAD_W == IN_W) begin : g_nopad
         assign win[0] = vec_i;
      end else begin : g_pad
         assign win[0] = {vec_i, {(PAD_W-IN_W){1'b0}}};
      end
   endgenerate

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         localparam int HALF = PAD_W >> (s + 1);
         logic top_empty;
         assign top_empty = ~|win[s][PAD_W-1 -: HALF];
         assign cnt[STAGES-1-s] = top_empty;
         if (s < STAGES - 1) begin : g_next
            assign win[s+1] = top_empty ? (win[s] << HALF) : win[s];
         end
      end
   endgenerate

   assign zeros_o = cnt;

endmodule

// File: rtl/fpu_field_classify.sv
// Decodes the exponent/fraction fields into a class code and flags
// the subnormal case that needs renormalization.
module fpu_field_classify
   import fpu_unpack_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W-1:0]  exp_fld_i,
   input  logic [FRAC_W-1:0] frac_fld_i,
   output fcls_e             cls_o,
   output logic              subnorm_o
);

   logic exp_ones, exp_zero, frac_zero;

   assign exp_ones  = &exp_fld_i;
   assign exp_zero  = ~|exp_fld_i;
   assign frac_zero = ~|frac_fld_i;

   always_comb begin
      subnorm_o = 1'b0;
      if (exp_ones) begin
         cls_o = frac_zero ? FCLS_INF : FCLS_NAN;
      end else if (exp_zero) begin
         if (frac_zero) begin
            cls_o = FCLS_ZERO;
         end else begin
            cls_o     = FCLS_NORM;
            subnorm_o = 1'b1;
         end
      end else begin
         cls_o = FCLS_NORM;
      end
   end

endmodule

// File: rtl/fpu_subnorm_align.sv
// Moves the leading one of a subnormal fraction to the hidden-bit
// position and derives the matching unbiased exponent.
module fpu_subnorm_align #(
   parameter int FRAC_W = 52,
   parameter int GRS_W  = 3,
   parameter int EXPO_W = 13,
   parameter int BIAS   = 1023,
   parameter int CNT_W  = 6
) (
   input  logic [FRAC_W-1:0] frac_i,
   input  logic [CNT_W-1:0]  lz_i,
   output logic [FRAC_W+GRS_W:0] mant_o,
   output logic [EXPO_W-1:0] exp_o
);

   localparam int MANT_W = FRAC_W + 1 + GRS_W;
   localparam logic [EXPO_W-1:0] NEG_BIAS = EXPO_W'(-BIAS);

   logic [CNT_W:0]      shamt;
   logic [MANT_W-1:0]   base;

   // Normal alignment already places fraction MSB one below the hidden
   // bit, so the leading one needs lz+1 more positions.
   assign shamt  = {1'b0, lz_i} + {{CNT_W{1'b0}}, 1'b1};
   assign base   = {1'b0, frac_i, {GRS_W{1'b0}}};
   assign mant_o = base << shamt;
   assign exp_o  = NEG_BIAS - {{(EXPO_W-CNT_W){1'b0}}, lz_i};

endmodule

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack
   import fpu_unpack_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int GRS_W  = 3,
   parameter int WORD_W = 1 + EXP_W + FRAC_W,
   parameter int EXPO_W = EXP_W + 2,
   parameter int MANT_W = FRAC_W + 1 + GRS_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_in,
   input  logic [WORD_W-1:0] word_in,
   output logic              valid_out,
   output logic [1:0]        class_out,
   output logic              sign_out,
   output logic [EXPO_W-1:0] exp_out,
   output logic [MANT_W-1:0] mant_out
);

   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam int PAD_W = pow2_ceil(FRAC_W);
   localparam int CNT_W = $clog2(PAD_W);
   localparam logic [EXPO_W-1:0] BIAS_V = EXPO_W'(BIAS);

   // Elaboration-time parameter checks.
   generate
      if (EXP_W < 2) begin : g_chk_exp
         $error("EXP_W must be at least 2");
      end
      if (FRAC_W < 2) begin : g_chk_frac
         $error("FRAC_W must be at least 2");
      end
      if (GRS_W < 1) begin : g_chk_grs
         $error("GRS_W must be at least 1");
      end
      if (WORD_W != 1 + EXP_W + FRAC_W) begin : g_chk_word
         $error("WORD_W must equal 1 + EXP_W + FRAC_W");
      end
      if (MANT_W != FRAC_W + 1 + GRS_W) begin : g_chk_mant
         $error("MANT_W must equal FRAC_W + 1 + GRS_W");
      end
      if ((1 << (EXPO_W - 1)) <= BIAS + FRAC_W) begin : g_chk_expo
         $error("EXPO_W too narrow for the smallest subnormal exponent");
      end
   endgenerate

   // Field split.
   logic              sgn_fld;
   logic [EXP_W-1:0]  exp_fld;
   logic [FRAC_W-1:0] frac_fld;

   assign sgn_fld  = word_in[WORD_W-1];
   assign exp_fld  = word_in[WORD_W-2 -: EXP_W];
   assign frac_fld = word_in[FRAC_W-1:0];

   fcls_e cls;
   logic  subnorm;

   fpu_field_classify #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_classify (
      .exp_fld_i  (exp_fld),
      .frac_fld_i (frac_fld),
      .cls_o      (cls),
      .subnorm_o  (subnorm)
   );

   logic [CNT_W-1:0] lz;

   fpu_lzc #(
      .IN_W  (FRAC_W),
      .PAD_W (PAD_W),
      .CNT_W (CNT_W)
   ) u_lzc (
      .vec_i   (frac_fld),
      .zeros_o (lz)
   );

   logic [MANT_W-1:0] sub_mant;
   logic [EXPO_W-1:0] sub_exp;

   fpu_subnorm_align #(
      .FRAC_W (FRAC_W),
      .GRS_W  (GRS_W),
      .EXPO_W (EXPO_W),
      .BIAS   (BIAS),
      .CNT_W  (CNT_W)
   ) u_align (
      .frac_i (frac_fld),
      .lz_i   (lz),
      .mant_o (sub_mant),
      .exp_o  (sub_exp)
   );

   // Result select.
   logic [MANT_W-1:0] nxt_mant;
   logic [EXPO_W-1:0] nxt_exp;

   always_comb begin
      nxt_mant = '0;
      nxt_exp  = '0;
      unique case (cls)
         FCLS_NORM: begin
            if (subnorm) begin
               nxt_mant = sub_mant;
               nxt_exp  = sub_exp;
            end else begin
               nxt_mant = {1'b1, frac_fld, {GRS_W{1'b0}}};
               nxt_exp  = {{(EXPO_W-EXP_W){1'b0}}, exp_fld} - BIAS_V;
            end
         end
         FCLS_NAN: begin
            nxt_mant = {1'b0, frac_fld, {GRS_W{1'b0}}};
         end
         default: begin
            nxt_mant = '0;
            nxt_exp  = '0;
         end
      endcase
   end

   // Output register: valid always follows, data loads only when valid.
   always_ff @(posedge clk) begin
      if (rst) begin
         valid_out <= 1'b0;
         class_out <= 2'b00;
         sign_out  <= 1'b0;
         exp_out   <= '0;
         mant_out  <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            class_out <= cls;
            sign_out  <= sgn_fld;
            exp_out   <= nxt_exp;
            mant_out  <= nxt_mant;
         end
      end
   end

endmodule

// File: rtl/fpu_unpack_chk.sv
module fpu_unpack_chk #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int GRS_W  = 3,
   parameter int WORD_W = 64,
   parameter int EXPO_W = 13,
   parameter int MANT_W = 56
) (
   input logic              clk,
   input logic              rst,
   input logic              valid_in,
   input logic [WORD_W-1:0] word_in,
   input logic              valid_out,
   input logic [1:0]        class_out,
   input logic              sign_out,
   input logic [EXPO_W-1:0] exp_out,
   input logic [MANT_W-1:0] mant_out
);

   logic in_ones, in_zero, in_fz;
   assign in_ones = &word_in[WORD_W-2 -: EXP_W];
   assign in_zero = ~|word_in[WORD_W-2 -: EXP_W];
   assign in_fz   = ~|word_in[FRAC_W-1:0];

   assert_sign_follows_R1: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> sign_out == $past(word_in[WORD_W-1]));

   assert_inf_code_R2: assert property (@(posedge clk) disable iff (rst)
      (valid_in && in_ones && in_fz) |=> (class_out == 2'b11 && mant_out == '0 && exp_out == '0));

   assert_nan_payload_R3: assert property (@(posedge clk) disable iff (rst)
      (valid_in && in_ones && !in_fz) |=> (class_out == 2'b10 && !mant_out[MANT_W-1] && mant_out != '0));

   assert_zero_clean_R4: assert property (@(posedge clk) disable iff (rst)
      (valid_out && class_out == 2'b01) |-> (mant_out == '0 && exp_out == '0));

   assert_norm_hidden_one_R5: assert property (@(posedge clk) disable iff (rst)
      (valid_out && class_out == 2'b00) |-> mant_out[MANT_W-1]);

   assert_subnorm_aligned_R6: assert property (@(posedge clk) disable iff (rst)
      (valid_in && in_zero && !in_fz) |=> (class_out == 2'b00 && mant_out[MANT_W-1] && mant_out[GRS_W-1:0] == '0));

   assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> valid_out == $past(valid_in));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> ($stable(class_out) && $stable(sign_out) && $stable(exp_out) && $stable(mant_out)));

   assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!valid_out && class_out == 2'b00 && mant_out == '0 && exp_out == '0 && !sign_out));

endmodule

bind fp_operand_unpack fpu_unpack_chk #(
   .EXP_W  (EXP_W),
   .FRAC_W (FRAC_W),
   .GRS_W  (GRS_W),
   .WORD_W (WORD_W),
   .EXPO_W (EXPO_W),
   .MANT_W (MANT_W)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .valid_in  (valid_in),
   .word_in   (word_in),
   .valid_out (valid_out),
   .class_out (class_out),
   .sign_out  (sign_out),
   .exp_out   (exp_out),
   .mant_out  (mant_out)
);

// File: tb/fp_operand_unpack_tb_top.sv
module fp_operand_unpack_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        valid_in;
   logic [63:0] word_in;
   logic        valid_out;
   logic [1:0]  class_out;
   logic        sign_out;
   logic [12:0] exp_out;
   logic [55:0] mant_out;

   always #10 clk = ~clk;  // 50 MHz

   fp_operand_unpack dut_i (
      .clk       (clk),
      .rst       (rst),
      .valid_in  (valid_in),
      .word_in   (word_in),
      .valid_out (valid_out),
      .class_out (class_out),
      .sign_out  (sign_out),
      .exp_out   (exp_out),
      .mant_out  (mant_out)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Model state: what the outputs must show at the next falling edge.
   logic        m_valid = 1'b0;
   logic [1:0]  m_cls   = 2'b00;
   logic        m_sign  = 1'b0;
   longint      m_exp   = 0;
   logic [55:0] m_mant  = '0;
   string       m_tag   = "R9";
   string       m_vtag  = "R9";
   string       m_stag  = "R9";

   task automatic cmp(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference from the requirement text.
   task automatic ref_unpack(input logic [63:0] w, output logic [1:0] cls,
                             output longint ex, output logic [55:0] mt, output string tag);
      int e;
      logic [51:0] f;
      e  = int'(w[62:52]);
      f  = w[51:0];
      ex = 0;
      mt = '0;
      if (e == 2047) begin
         if (f == 0) begin
            cls = 2'b11; tag = "R2";
         end else begin
            cls = 2'b10; tag = "R3";
            mt  = {4'b0000, f} << 3;
         end
      end else if (e == 0) begin
         if (f == 0) begin
            cls = 2'b01; tag = "R4";
         end else begin
            int p;
            p = 0;
            for (int i = 0; i < 52; i++) if (f[i]) p = i;
            cls = 2'b00; tag = "R6";
            mt  = {4'b0000, f} << (55 - p);
            ex  = -1074 + p;
         end
      end else begin
         cls = 2'b00; tag = "R5";
         mt  = {3'b000, 1'b1, f} << 3;
         ex  = e - 1023;
      end
   endtask

   task automatic step(input bit r, input bit v, input logic [63:0] w);
      @(negedge clk);
      cmp(m_vtag, "valid_out", longint'(valid_out), longint'(m_valid));
      cmp(m_tag,  "class_out", longint'(class_out), longint'(m_cls));
      cmp(m_stag, "sign_out",  longint'(sign_out),  longint'(m_sign));
      cmp(m_tag,  "exp_out",   longint'($signed(exp_out)), m_exp);
      cmp(m_tag,  "mant_out",  longint'(mant_out),  longint'(m_mant));
      if (r) begin
         m_valid = 1'b0; m_cls = 2'b00; m_sign = 1'b0; m_exp = 0; m_mant = '0;
         m_tag = "R9"; m_vtag = "R9"; m_stag = "R9";
      end else if (v) begin
         logic [1:0]  c;
         longint      x;
         logic [55:0] mm;
         string       t;
         ref_unpack(w, c, x, mm, t);
         m_valid = 1'b1; m_cls = c; m_sign = w[63]; m_exp = x; m_mant = mm;
         m_tag = t; m_vtag = "R7"; m_stag = "R1";
      end else begin
         m_valid = 1'b0;
         m_tag = "R8"; m_vtag = "R7"; m_stag = "R8";
      end
      rst      = r;
      valid_in = v;
      word_in  = w;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R7 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] s;
      rst = 1'b1; valid_in = 1'b0; word_in = '0;
      // Reset with busy inputs: R9
      step(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      step(1'b1, 1'b0, 64'h0);
      step(1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0);
      // Normals R5, back to back R7
      step(1'b0, 1'b1, 64'h3FF0_0000_0000_0000);
      step(1'b0, 1'b1, 64'hC004_0000_0000_0000);
      step(1'b0, 1'b1, 64'h7FEF_FFFF_FFFF_FFFF);
      step(1'b0, 1'b1, 64'h0010_0000_0000_0000);
      // Specials R2 R3 R4
      step(1'b0, 1'b1, 64'h7FF0_0000_0000_0000);
      step(1'b0, 1'b1, 64'hFFF0_0000_0000_0000);
      step(1'b0, 1'b1, 64'h7FF8_0000_0000_0000);
      step(1'b0, 1'b1, 64'h7FF0_0000_0000_0001);
      step(1'b0, 1'b1, 64'h0000_0000_0000_0000);
      step(1'b0, 1'b1, 64'h8000_0000_0000_0000);
      // Subnormals R6
      step(1'b0, 1'b1, 64'h0000_0000_0000_0001);
      step(1'b0, 1'b1, 64'h000F_FFFF_FFFF_FFFF);
      step(1'b0, 1'b1, 64'h0008_0000_0000_0000);
      step(1'b0, 1'b1, 64'h8000_0000_0000_0400);
      // Idle with changing data: R8 hold
      step(1'b0, 1'b0, 64'h7FF0_0000_0000_0000);
      step(1'b0, 1'b0, 64'h3FF0_0000_0000_0000);
      step(1'b0, 1'b1, 64'h4000_0000_0000_0001);
      step(1'b0, 1'b0, 64'h0);
      // Reset mid-stream after a valid operand: R9
      step(1'b0, 1'b1, 64'hBFF8_0000_0000_0000);
      step(1'b1, 1'b1, 64'h7FF8_0000_0000_0000);
      step(1'b0, 1'b0, 64'h0);
      // Pseudo-random stream biased to edge exponents
      s = 64'h9E37_79B9_7F4A_7C15;
      for (int n = 0; n < 3000; n++) begin
         logic [63:0] w;
         s = s ^ (s << 13);
         s = s ^ (s >> 7);
         s = s ^ (s << 17);
         w = s;
         case (s[3:0])
            4'd0, 4'd1: w[62:52] = '0;
            4'd2:       w[62:52] = '1;
            4'd3:       w[51:0]  = '0;
            4'd4:       begin w[62:52] = '0; w[51:0] = 52'd1 << s[9:4]; end
            default:    ;
         endcase
         step(1'b0, s[7:5] != 3'd0, w);
      end
      step(1'b0, 1'b0, 64'h0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule